// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After every reset this block decides whether a serial configuration EEPROM is fitted. If one is, it reads a self-describing configuration block from it, one 16-bit word per transaction. It does this over a four-wire serial link: select, clock, command out and data in. The loader parses the block into groups of register initialisations and keeps each decoded write in a local staging store.

The staged writes go out to the rest of the chip on a plain address/data/strobe port, and only after the whole block has passed its byte checksum. A blank first word, a missing EEPROM or a malformed block leaves every register at its default. In all of these cases the block raises a completion flag, and an error flag when the content was rejected.

The block header gives the block length. Each group header gives a word count and a start register address. Words of all ones act as end markers.

Top module: `cfg_rom_loader`

## Requirements
- R1: The level of `ee_di` while `rst` is high is captured in `ee_found`. If it was low, `ee_cs` never rises, no register write occurs, `cfg_err` stays low and `init_done` rises.
- R2: `ee_sk` is low whenever `ee_cs` is low. Within a transaction its period is 2*SK_HALF clocks, which is 20 clocks or 1 MHz from a 20 MHz clock at the default.
- R3: Each transaction holds `ee_cs` high while 11 command bits go out on `ee_do`, changed while `ee_sk` is low and MSB first: a start bit 1, opcode 10, then the 8-bit word address. Sixteen data bits follow, sampled from `ee_di` on rising `ee_sk`, MSB first. Word addresses are read in ascending order starting at 0.
- R4: If word 0 reads FFFFh, no further word is read, no write occurs, `cfg_err` stays low and `init_done` rises.
- R5: Bits 7:1 of word 0 give N, where the low byte of word 0 is the number of bytes after the header, checksum included. Words 1..N are then read. If N is 0, `cfg_err` is set and no further word is read.
- R6: A group header word carries a data word count in bits 15:12 and a 12-bit register address in bits 11:0. Its data words are written to that address, then address+2 and so on, wrapping within 12 bits. A count of 0 writes nothing, and the next word is again a group header.
- R7: A group header of FFFFh ends group parsing. The words that follow it, up to the checksum word, are summed but never written.
- R8: Word N is always the checksum word. The 8-bit sum of both bytes of words 0..N must be 00h, otherwise `cfg_err` is set and no write occurs.
- R9: Accepted writes appear on `reg_we`/`reg_addr`/`reg_wdata` only after the checksum word has been read. They come in block order on consecutive clocks, one clock each, and never while `ee_cs` is high.
- R10: A block holding more than STAGE_DEPTH data words sets `cfg_err` and produces no write.
- R11: `init_done` rises once loading ends and stays high until the next reset. `cfg_err` is never high without `init_done`.
- R12: While `rst` is high, `reg_we`, `ee_cs`, `ee_sk`, `ee_do`, `init_done` and `cfg_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Command bits to the EEPROM |
| ee_di | input | 1 | Data from the EEPROM; its level during reset signals presence |
| reg_we | output | 1 | Register write strobe, one clock per write |
| reg_addr | output | 12 | Register write address |
| reg_wdata | output | 16 | Register write data |
| ee_found | output | 1 | EEPROM was sensed during reset |
| init_done | output | 1 | Loading finished |
| cfg_err | output | 1 | Block rejected (length, checksum or overflow) |

## Verification
The bench aims at the points where a plausible loader slips. One is a checksum that is off by one, which must suppress every write; a design that writes while it parses would leak those writes anyway. Other points are a group running across the 12-bit address wrap, a zero-count group, an all-ones terminator followed by a decoy group that would be written if the terminator were ignored, and a blank first word or zero length, where an eager design would keep reading. An overflowing block checks that a design which silently drops the extra words, instead of flagging them, is caught. The EEPROM model also checks the start bit, the opcode, the sequential addresses and the clock period of every transaction.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int WORD_W  = 16;
  localparam int BYTE_W  = 8;
  localparam int RADDR_W = 12;
  localparam int EADDR_W = 8;
  localparam int GCNT_W  = WORD_W - RADDR_W;
  localparam int CMD_W   = 3 + EADDR_W;
  localparam logic [1:0] OP_READ = 2'b10;
  localparam logic [WORD_W-1:0] BLANK_WORD = '1;

  typedef struct packed {
    logic [RADDR_W-1:0] addr;
    logic [WORD_W-1:0]  data;
  } reg_wr_t;

  function automatic logic [CMD_W-1:0] read_cmd(input logic [EADDR_W-1:0] a);
    return {1'b1, OP_READ, a};
  endfunction
endpackage

// File: rtl/cfgld_mw_reader.sv
module cfgld_mw_reader
  import cfgld_pkg::*;
#(
  parameter int SK_HALF = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_req,
  input  logic [EADDR_W-1:0] rd_addr,
  output logic               rd_done,
  output logic [WORD_W-1:0]  rd_word,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_do,
  input  logic               ee_di
);
  localparam int TOT_BITS = CMD_W + WORD_W;
  localparam int DIV_W    = $clog2(SK_HALF + 1);
  localparam int BIT_W    = $clog2(TOT_BITS + 1);

  typedef enum logic [1:0] {R_IDLE, R_LOW, R_HIGH, R_GAP} rstate_t;
  rstate_t st;

  logic [DIV_W-1:0]  div;
  logic [BIT_W-1:0]  bitn;
  logic [CMD_W-1:0]  cmd_sr;
  logic [WORD_W-1:0] sh;
  logic              half_end;

  assign half_end = (div == DIV_W'(SK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= R_IDLE;
      div     <= '0;
      bitn    <= '0;
      cmd_sr  <= '0;
      sh      <= '0;
      rd_done <= 1'b0;
      rd_word <= '0;
      ee_cs   <= 1'b0;
      ee_sk   <= 1'b0;
      ee_do   <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      case (st)
        R_IDLE: if (rd_req) begin
          cmd_sr <= read_cmd(rd_addr);
          ee_cs  <= 1'b1;
          ee_sk  <= 1'b0;
          ee_do  <= 1'b1;
          bitn   <= '0;
          div    <= '0;
          st     <= R_LOW;
        end
        R_LOW: if (half_end) begin
          div   <= '0;
          ee_sk <= 1'b1;
          if (bitn >= BIT_W'(CMD_W)) sh <= {sh[WORD_W-2:0], ee_di};
          st    <= R_HIGH;
        end else begin
          div <= div + 1'b1;
        end
        R_HIGH: if (half_end) begin
          div   <= '0;
          ee_sk <= 1'b0;
          if (bitn == BIT_W'(TOT_BITS - 1)) begin
            ee_cs <= 1'b0;
            ee_do <= 1'b0;
            st    <= R_GAP;
          end else begin
            bitn   <= bitn + 1'b1;
            cmd_sr <= cmd_sr << 1;
            ee_do  <= cmd_sr[CMD_W-2] & (bitn < BIT_W'(CMD_W - 1));
            st     <= R_LOW;
          end
        end else begin
          div <= div + 1'b1;
        end
        R_GAP: if (half_end) begin
          div     <= '0;
          rd_done <= 1'b1;
          rd_word <= sh;
          st      <= R_IDLE;
        end else begin
          div <= div + 1'b1;
        end
        default: st <= R_IDLE;
      endcase
    end
  end

  // R2
  sk_cs_chk: assert property (@(posedge clk) disable iff (rst) !ee_cs |-> !ee_sk);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) rd_done |=> !rd_done);
endmodule

// File: rtl/cfgld_stage.sv
module cfgld_stage
  import cfgld_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    push,
  input  reg_wr_t push_ent,
  output logic    full,
  input  logic    play,
  output logic    play_done,
  output logic    out_we,
  output reg_wr_t out_ent
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  reg_wr_t          mem [DEPTH];
  logic [PTR_W-1:0] cnt;
  logic [PTR_W-1:0] rd_ptr;
  logic             playing;

  assign full = (cnt == PTR_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (push && !full) mem[cnt[IDX_W-1:0]] <= push_ent;
  end

  always_ff @(posedge clk) begin
    out_ent <= mem[rd_ptr[IDX_W-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      rd_ptr    <= '0;
      playing   <= 1'b0;
      play_done <= 1'b0;
      out_we    <= 1'b0;
    end else begin
      play_done <= 1'b0;
      if (push && !full) cnt <= cnt + 1'b1;
      out_we <= playing && !play && (rd_ptr != cnt);
      if (play) begin
        playing <= 1'b1;
        rd_ptr  <= '0;
      end else if (playing) begin
        if (rd_ptr != cnt) begin
          rd_ptr <= rd_ptr + 1'b1;
        end else begin
          playing   <= 1'b0;
          play_done <= 1'b1;
        end
      end
    end
  end

  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ee_di,
  output logic               rd_req,
  output logic [EADDR_W-1:0] rd_addr,
  input  logic               rd_done,
  input  logic [WORD_W-1:0]  rd_word,
  output logic               push,
  output reg_wr_t            push_ent,
  input  logic               full,
  output logic               play,
  input  logic               play_done,
  output logic               ee_found,
  output logic               init_done,
  output logic               cfg_err
);
  typedef enum logic [2:0] {Q_SENSE, Q_ISSUE, Q_WAIT, Q_PLAY, Q_END} qstate_t;
  qstate_t st;

  logic [BYTE_W-1:0]  sum;
  logic [BYTE_W-1:0]  sum_n;
  logic [EADDR_W-1:0] last_idx;
  logic [GCNT_W-1:0]  grp_left;
  logic [RADDR_W-1:0] grp_addr;
  logic               pad;
  logic               ovf;

  assign sum_n = sum + rd_word[WORD_W-1 -: BYTE_W] + rd_word[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= Q_SENSE;
      ee_found  <= ee_di;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      push      <= 1'b0;
      push_ent  <= '0;
      play      <= 1'b0;
      init_done <= 1'b0;
      cfg_err   <= 1'b0;
      sum       <= '0;
      last_idx  <= '0;
      grp_left  <= '0;
      grp_addr  <= '0;
      pad       <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      push   <= 1'b0;
      play   <= 1'b0;
      case (st)
        Q_SENSE: begin
          if (ee_found) begin
            st <= Q_ISSUE;
          end else begin
            init_done <= 1'b1;
            st        <= Q_END;
          end
        end
        Q_ISSUE: begin
          rd_req <= 1'b1;
          st     <= Q_WAIT;
        end
        Q_WAIT: if (rd_done) begin
          sum <= sum_n;
          if (rd_addr == '0) begin
            if (rd_word == BLANK_WORD) begin
              init_done <= 1'b1;
              st        <= Q_END;
            end else if (rd_word[BYTE_W-1:1] == '0) begin
              cfg_err   <= 1'b1;
              init_done <= 1'b1;
              st        <= Q_END;
            end else begin
              last_idx <= EADDR_W'(rd_word[BYTE_W-1:1]);
              rd_addr  <= rd_addr + 1'b1;
              st       <= Q_ISSUE;
            end
          end else if (rd_addr == last_idx) begin
            if (sum_n == '0 && !ovf) begin
              play <= 1'b1;
              st   <= Q_PLAY;
            end else begin
              cfg_err   <= 1'b1;
              init_done <= 1'b1;
              st        <= Q_END;
            end
          end else begin
            rd_addr <= rd_addr + 1'b1;
            st      <= Q_ISSUE;
            if (!pad) begin
              if (grp_left == '0) begin
                if (rd_word == BLANK_WORD) begin
                  pad <= 1'b1;
                end else begin
                  grp_left <= rd_word[WORD_W-1 -: GCNT_W];
                  grp_addr <= rd_word[RADDR_W-1:0];
                end
              end else begin
                if (full) begin
                  ovf <= 1'b1;
                end else begin
                  push          <= 1'b1;
                  push_ent.addr <= grp_addr;
                  push_ent.data <= rd_word;
                end
                grp_addr <= grp_addr + RADDR_W'(2);
                grp_left <= grp_left - 1'b1;
              end
            end
          end
        end
        Q_PLAY: if (play_done) begin
          init_done <= 1'b1;
          st        <= Q_END;
        end
        Q_END: st <= Q_END;
        default: st <= Q_END;
      endcase
    end
  end

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (rst) init_done |=> init_done);
  // R11
  err_done_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |-> init_done);
  // R4
  no_read_after_done_chk: assert property (@(posedge clk) disable iff (rst) rd_req |-> !init_done);
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfgld_pkg::*;
#(
  parameter int SK_HALF     = 10,
  parameter int STAGE_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic               ee_cs,
  output logic               ee_sk,
  output logic               ee_do,
  input  logic               ee_di,
  output logic               reg_we,
  output logic [RADDR_W-1:0] reg_addr,
  output logic [WORD_W-1:0]  reg_wdata,
  output logic               ee_found,
  output logic               init_done,
  output logic               cfg_err
);
  logic               rd_req;
  logic [EADDR_W-1:0] rd_addr;
  logic               rd_done;
  logic [WORD_W-1:0]  rd_word;
  logic               push;
  reg_wr_t            push_ent;
  logic               full;
  logic               play;
  logic               play_done;
  reg_wr_t            out_ent;

  cfgld_mw_reader #(.SK_HALF(SK_HALF)) u_reader (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_done(rd_done), .rd_word(rd_word),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di)
  );

  cfgld_seq u_seq (
    .clk(clk), .rst(rst), .ee_di(ee_di),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_done(rd_done), .rd_word(rd_word),
    .push(push), .push_ent(push_ent), .full(full),
    .play(play), .play_done(play_done),
    .ee_found(ee_found), .init_done(init_done), .cfg_err(cfg_err)
  );

  cfgld_stage #(.DEPTH(STAGE_DEPTH)) u_stage (
    .clk(clk), .rst(rst), .push(push), .push_ent(push_ent), .full(full),
    .play(play), .play_done(play_done), .out_we(reg_we), .out_ent(out_ent)
  );

  assign reg_addr  = out_ent.addr;
  assign reg_wdata = out_ent.data;

  // R1
  absent_quiet_chk: assert property (@(posedge clk) disable iff (rst) !ee_found |-> !ee_cs);
  // R9
  we_outside_cs_chk: assert property (@(posedge clk) disable iff (rst) reg_we |-> !ee_cs);
  // R8
  we_no_err_chk: assert property (@(posedge clk) disable iff (rst) reg_we |-> !cfg_err);
endmodule

// File: tb/test_cfg_rom_loader.sv
`timescale 1ns/1ps
module test_cfg_rom_loader;
  localparam int SK_HALF = 10;
  localparam int DEPTH   = 32;
  localparam int NVEC    = 9;
  // {present, kind, group1 count, group2 count, base address}
  // kind: 0 normal, 1 blank first word, 2 bad checksum, 3 terminator, 4 zero length, 5 overflow
  localparam logic [23:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 4'd2,  4'd1, 12'h010},
    {1'b1, 3'd0, 4'd3,  4'd2, 12'h040},
    {1'b1, 3'd0, 4'd2,  4'd0, 12'hFFE},
    {1'b1, 3'd1, 4'd0,  4'd0, 12'h000},
    {1'b1, 3'd2, 4'd2,  4'd2, 12'h100},
    {1'b1, 3'd3, 4'd2,  4'd3, 12'h200},
    {1'b1, 3'd4, 4'd0,  4'd0, 12'h000},
    {1'b1, 3'd5, 4'd0,  4'd0, 12'h000},
    {1'b1, 3'd0, 4'd15, 4'd1, 12'h300}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        present = 1'b0;
  logic        ee_cs, ee_sk, ee_do, ee_di;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [15:0] reg_wdata;
  logic        ee_found, init_done, cfg_err;

  always #10 clk = ~clk;

  cfg_rom_loader #(.SK_HALF(SK_HALF), .STAGE_DEPTH(DEPTH)) i_cfg_rom_loader (
    .clk(clk), .rst(rst), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ee_found(ee_found), .init_done(init_done), .cfg_err(cfg_err)
  );

  // Behavioural serial EEPROM
  logic [15:0] eemem [256];
  logic        mdl_di = 1'b1;
  int          mbits = 0;
  logic [10:0] mcmd = '0;
  logic [15:0] mdata = '0;
  int          msent = 0;
  int          nreads = 0;
  int          fmt_err = 0;

  assign ee_di = present ? mdl_di : 1'b0;

  always @(posedge ee_sk) begin
    if (ee_cs && mbits < 11) begin
      mcmd  = {mcmd[9:0], ee_do};
      mbits = mbits + 1;
      if (mbits == 11) begin
        if (mcmd[10:8] != 3'b110 || mcmd[7:0] != 8'(nreads)) fmt_err = fmt_err + 1;
        mdata  = eemem[mcmd[7:0]];
        nreads = nreads + 1;
        msent  = 0;
      end
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs && mbits == 11 && msent < 16) begin
      mdl_di = mdata[15 - msent];
      msent  = msent + 1;
    end
  end

  always @(negedge ee_cs) begin
    mbits  = 0;
    mdl_di = 1'b1;
  end

  // Output monitor, sampled away from the active edge
  int          cyc = 0;
  int          nwr = 0;
  logic [11:0] wa [64];
  logic [15:0] wd [64];
  int          wcyc [64];
  int          we_cs_bad = 0;
  int          skbad = 0;
  int          last_rise = -1;
  int          pmin = 1000000;
  int          pmax = 0;
  int          per = 0;
  logic        sk_prev = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (reg_we && nwr < 64) begin
        wa[nwr]   = reg_addr;
        wd[nwr]   = reg_wdata;
        wcyc[nwr] = cyc;
        nwr       = nwr + 1;
      end
      if (reg_we && ee_cs) we_cs_bad = we_cs_bad + 1;
      if (!ee_cs && ee_sk) skbad = skbad + 1;
      if (!ee_cs) begin
        last_rise = -1;
      end else if (ee_sk && !sk_prev) begin
        if (last_rise >= 0) begin
          per = cyc - last_rise;
          if (per < pmin) pmin = per;
          if (per > pmax) pmax = per;
        end
        last_rise = cyc;
      end
    end
    sk_prev = ee_sk;
  end

  // Checking
  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk = nchk + 1;
    if (!ok) begin
      nfail = nfail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  int wd_cnt = 0;
  always @(posedge clk) begin
    wd_cnt = wd_cnt + 1;
    if (wd_cnt > 190000) begin
      nfail = nfail + 1;
      $display("FAIL R11 watchdog: actual %0d expected %0d", wd_cnt, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // Expected results, built from the requirements
  logic [11:0] exp_addr [64];
  logic [15:0] exp_data [64];
  int          nexp = 0;
  int          exp_reads = 0;
  bit          exp_err = 1'b0;

  task automatic add_grp(inout int p, input int n, input logic [11:0] a0, inout int k, input int vi);
    logic [11:0] a;
    logic [15:0] d;
    a = a0;
    eemem[p] = {4'(n), a0};
    p = p + 1;
    for (int j = 0; j < n; j++) begin
      d = 16'h2F00 + 16'(k * 16'h0137) + 16'(vi);
      eemem[p] = d;
      p = p + 1;
      if (nexp < 64) begin
        exp_addr[nexp] = a;
        exp_data[nexp] = d;
        nexp = nexp + 1;
      end
      a = a + 12'd2;
      k = k + 1;
    end
  endtask

  task automatic build(input logic [23:0] vc, input int vi);
    int         p;
    int         k;
    logic [7:0] s;
    logic [2:0] kind;
    kind = vc[22:20];
    for (int i = 0; i < 256; i++) eemem[i] = 16'hFFFF;
    nexp = 0;
    exp_err = 1'b0;
    exp_reads = 0;
    k = 0;
    p = 1;
    if (!vc[23]) begin
      exp_reads = 0;
    end else if (kind == 3'd1) begin
      exp_reads = 1;
    end else if (kind == 3'd4) begin
      eemem[0] = 16'h5A01;
      exp_reads = 1;
      exp_err = 1'b1;
    end else begin
      if (kind == 3'd5) begin
        add_grp(p, 15, 12'h400, k, vi);
        add_grp(p, 15, 12'h500, k, vi);
        add_grp(p, 3, 12'h600, k, vi);
      end else begin
        add_grp(p, int'(vc[19:16]), vc[11:0], k, vi);
        add_grp(p, int'(vc[15:12]), vc[11:0] + 12'h100, k, vi);
      end
      if (kind == 3'd3) begin
        eemem[p]   = 16'hFFFF;
        eemem[p+1] = {4'd2, 12'h7F0};
        eemem[p+2] = 16'h1234;
        eemem[p+3] = 16'h5678;
        p = p + 4;
      end
      eemem[0] = {8'h3C, 8'(2 * p)};
      s = 8'h00;
      for (int i = 0; i < p; i++) s = s + eemem[i][15:8] + eemem[i][7:0];
      eemem[p] = {8'h00, 8'h00 - s};
      if (kind == 3'd2) eemem[p] = eemem[p] + 16'd1;
      exp_reads = p + 1;
      if (kind == 3'd2 || kind == 3'd5) begin
        exp_err = 1'b1;
        nexp = 0;
      end
    end
  endtask

  task automatic run_vec(input logic [23:0] vc, input int vi);
    string tag;
    int    t;
    int    bad;
    case (vc[22:20])
      3'd1: tag = "R4";
      3'd2: tag = "R8";
      3'd3: tag = "R7";
      3'd4: tag = "R5";
      3'd5: tag = "R10";
      default: tag = "R6";
    endcase
    if (!vc[23]) tag = "R1";
    build(vc, vi);
    present = vc[23];
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    chk(!reg_we && !ee_cs && !ee_sk && !ee_do && !init_done && !cfg_err, "R12",
        int'({reg_we, ee_cs, ee_sk, ee_do, init_done, cfg_err}), 0);
    nreads = 0;
    fmt_err = 0;
    nwr = 0;
    we_cs_bad = 0;
    skbad = 0;
    pmin = 1000000;
    pmax = 0;
    last_rise = -1;
    rst = 1'b0;
    t = 0;
    while (!init_done && t < 60000) begin
      @(negedge clk);
      t = t + 1;
    end
    chk(init_done == 1'b1, "R11", int'(init_done), 1);
    repeat (40) @(negedge clk);
    chk(init_done == 1'b1, "R11", int'(init_done), 1);
    chk(ee_found == present, "R1", int'(ee_found), int'(present));
    chk(cfg_err == exp_err, tag, int'(cfg_err), int'(exp_err));
    chk(nreads == exp_reads, vc[23] ? "R5" : "R1", nreads, exp_reads);
    chk(fmt_err == 0, "R3", fmt_err, 0);
    chk(nwr == nexp, tag, nwr, nexp);
    bad = 0;
    for (int i = 0; i < nwr && i < nexp; i++) begin
      if (wa[i] != exp_addr[i] || wd[i] != exp_data[i]) bad = bad + 1;
    end
    chk(bad == 0, tag, bad, 0);
    if (nwr > 1) chk(wcyc[nwr-1] - wcyc[0] == nwr - 1, "R9", wcyc[nwr-1] - wcyc[0], nwr - 1);
    chk(we_cs_bad == 0, "R9", we_cs_bad, 0);
    chk(skbad == 0, "R2", skbad, 0);
    if (nreads > 0) chk(pmin == 2 * SK_HALF && pmax == 2 * SK_HALF, "R2", pmax, 2 * SK_HALF);
  endtask

  initial begin
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v], v);
    // Directed: reset in the middle of a load clears completion (R12)
    build(VEC[1], 1);
    present = 1'b1;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (700) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !init_done && !reg_we, "R12",
        int'({ee_cs, ee_sk, init_done, reg_we}), 0);
    rst = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule